// File: doc/BRIEF.md
# Register-Dump Trace Entry Writer

This block builds the explicit trace record that a trace instruction produces and writes it to memory as a stream of 32-bit words, one word per clock. A record begins with a header word. The header carries a format tag, the number of dumped registers and the high part of a timestamp. The rest of the timestamp follows, then a 32-bit operand, then a run of general registers that starts at `first_reg` and counts upward, wrapping past 15, until it reaches `last_reg`.

All request fields are captured on the `start` strobe. The block then reads the register file one index at a time through a combinational read port. It writes consecutive words from `base_addr` upward. When the record is complete it pulses `done` and reports the total record length in bytes. Two forms exist. In the narrow form each register gives one word. In the wide form each register gives two words and the timestamp takes one extra word.

Top module: `trace_dump_writer`

## Requirements
- R1: The register count minus one is n = (last_reg − first_reg) mod 16. Registers are written in the order first_reg, first_reg+1, … wrapping from 15 to 0, ending with last_reg, and `rf_idx` presents each index in the cycle its data is written.
- R2: The first word written has bits 31:24 equal to 0x70 OR n. Its bits 23:16 are 0x00 in the narrow form (`wide_mode`=0) and 0x80 in the wide form (`wide_mode`=1).
- R3: In the narrow form, with T = (clock_val << 8) | cpu_id taken to 64 bits, word 0 bits 15:0 hold T[47:32], word 1 holds T[31:0], word 2 holds the operand, and word 3+i holds bits 31:0 of the i-th register.
- R4: In the wide form, word 0 bits 15:0 hold clock_val[63:48], word 1 holds T[63:32], word 2 holds T[31:0] and word 3 holds the operand.
- R5: In the wide form, register i takes words 4+2i (bits 63:32) and 5+2i (bits 31:0), high word first.
- R6: Word k is written at `base_addr` + 4k. `wr_en` stays high for exactly 3+(n+1) cycles in the narrow form or 4+2(n+1) cycles in the wide form, with no gaps, starting the cycle after the accepted `start`.
- R7: `done` is high for exactly one cycle, the cycle after the last write. At that cycle `done_size` equals 76 − (15−n)·4 in the narrow form and 144 − (15−n)·8 in the wide form.
- R8: A `start` seen while `busy` is high is ignored: the record being written, its addresses and its length are unchanged even if every request input changes.
- R9: After reset `busy`, `wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| first_reg | input | 4 | First register of the dump range |
| last_reg | input | 4 | Last register of the dump range |
| operand | input | 32 | Operand word stored in the record |
| wide_mode | input | 1 | 0: 32-bit registers, 1: 64-bit registers |
| clock_val | input | 64 | Clock value for the timestamp |
| cpu_id | input | 8 | Processor address merged into the timestamp |
| rf_idx | output | 4 | Register file read index |
| rf_data | input | 64 | Register file read data for `rf_idx` |
| base_addr | input | 32 | Byte address of the record's first word |
| wr_addr | output | 32 | Word write byte address |
| wr_data | output | 32 | Word write data |
| wr_en | output | 1 | Word write enable |
| busy | output | 1 | Record in progress |
| done | output | 1 | One-cycle completion pulse |
| done_size | output | 8 | Record length in bytes, valid with `done` |

## Verification
A wrong word counter or register offset shows at once. The register index, the data word or the address goes wrong in the very cycle concerned, and the bench compares every written word, address and index against an arithmetic model. A wrong count, wrap or form flag shows later. It moves the final write and the `done` pulse, so it is caught within one record. Every first/last pair in both forms is swept, and a stray `start` with altered inputs is injected mid-record, so a capture that leaks through busy shows up in the next written word.

// File: rtl/trace_dump_writer.sv
module trace_dump_writer #(
  parameter int ADDR_W = 32,
  parameter int CLK_W  = 64,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        first_reg,
  input  logic [3:0]        last_reg,
  input  logic [31:0]       operand,
  input  logic              wide_mode,
  input  logic [CLK_W-1:0]  clock_val,
  input  logic [ID_W-1:0]   cpu_id,
  output logic [3:0]        rf_idx,
  input  logic [63:0]       rf_data,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              wr_en,
  output logic              busy,
  output logic              done,
  output logic [7:0]        done_size
);

  localparam int KW = 6;

  logic              busy_q, done_q, wide_q;
  logic [KW-1:0]     k_q;
  logic [3:0]        n_q, r1_q;
  logic [31:0]       op_q;
  logic [CLK_W-1:0]  clk_q;
  logic [ID_W-1:0]   id_q;
  logic [ADDR_W-1:0] base_q;
  logic [7:0]        size_q;

  logic [63:0]   ts;
  logic [KW-1:0] hdr, tot, j;
  logic [3:0]    off;
  logic          last;
  logic [7:0]    size_c;

  assign ts     = {clk_q[CLK_W-ID_W-1:0], id_q};
  assign hdr    = wide_q ? KW'(4) : KW'(3);
  assign tot    = wide_q ? ({1'b0, n_q, 1'b0} + KW'(6)) : ({2'b0, n_q} + KW'(4));
  assign last   = (k_q == tot - KW'(1));
  assign j      = k_q - hdr;
  assign off    = wide_q ? j[4:1] : j[3:0];
  assign rf_idx = r1_q + off;
  assign size_c = wide_q ? ({1'b0, n_q, 3'b0} + 8'd24) : ({2'b0, n_q, 2'b0} + 8'd16);

  assign busy      = busy_q;
  assign wr_en     = busy_q;
  assign done      = done_q;
  assign done_size = size_q;
  assign wr_addr   = base_q + {{(ADDR_W-KW-2){1'b0}}, k_q, 2'b00};

  always_comb begin
    wr_data = 32'h0;
    if (k_q == '0)
      wr_data = {4'h7, n_q, wide_q ? 8'h80 : 8'h00,
                 wide_q ? clk_q[CLK_W-1:CLK_W-16] : ts[47:32]};
    else if (wide_q) begin
      case (k_q)
        KW'(1):  wr_data = ts[63:32];
        KW'(2):  wr_data = ts[31:0];
        KW'(3):  wr_data = op_q;
        default: wr_data = j[0] ? rf_data[31:0] : rf_data[63:32];
      endcase
    end else begin
      case (k_q)
        KW'(1):  wr_data = ts[31:0];
        KW'(2):  wr_data = op_q;
        default: wr_data = rf_data[31:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      wide_q <= 1'b0;
      k_q    <= '0;
      n_q    <= '0;
      r1_q   <= '0;
      op_q   <= '0;
      clk_q  <= '0;
      id_q   <= '0;
      base_q <= '0;
      size_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          k_q    <= '0;
          n_q    <= last_reg - first_reg;
          r1_q   <= first_reg;
          wide_q <= wide_mode;
          op_q   <= operand;
          clk_q  <= clock_val;
          id_q   <= cpu_id;
          base_q <= base_addr;
        end
      end else if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        size_q <= size_c;
      end else begin
        k_q <= k_q + KW'(1);
      end
    end
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + ADDR_W'(4));

  // R6
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_addr == $past(base_addr));

  // R2
  header_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_data[31:28] == 4'h7);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && !wr_en);

  // R8
  stay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy);

endmodule

// File: tb/tb_trace_dump_writer.sv
module tb_trace_dump_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  first_reg = '0, last_reg = '0, rf_idx;
  logic [31:0] operand = '0, base_addr = '0, wr_addr, wr_data;
  logic        wide_mode = 1'b0, wr_en, busy, done;
  logic [63:0] clock_val = '0, rf_data;
  logic [7:0]  cpu_id = '0, done_size;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  function automatic logic [63:0] reg_val(input logic [3:0] i);
    reg_val = {32'h9000_0000 + 32'(i) * 32'h0101_0003,
               32'h0600_0000 + 32'(i) * 32'h0011_0207};
  endfunction

  assign rf_data = reg_val(rf_idx);

  trace_dump_writer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .first_reg(first_reg),
    .last_reg(last_reg), .operand(operand), .wide_mode(wide_mode),
    .clock_val(clock_val), .cpu_id(cpu_id), .rf_idx(rf_idx),
    .rf_data(rf_data), .base_addr(base_addr), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en), .busy(busy), .done(done),
    .done_size(done_size));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic run_entry(input int r1, input int r3, input bit wd,
                           input int seq, input bit inject);
    int n, words;
    logic [63:0] tod, ts;
    logic [31:0] op, base, exp;
    logic [7:0] cid;
    n = (r3 - r1) & 15;
    words = wd ? 4 + 2 * (n + 1) : 3 + (n + 1);
    tod  = 64'h0123_4567_89AB_CDEF ^ (64'(seq) * 64'h9E37_79B9_7F4A_7C15);
    cid  = 8'(seq * 37 + 5);
    op   = 32'hD00D_0000 ^ 32'(seq * 977);
    base = 32'h0001_0000 + 32'(seq) * 32'h100;
    ts   = (tod << 8) | 64'(cid);
    @(negedge clk);
    first_reg = 4'(r1); last_reg = 4'(r3); wide_mode = wd;
    clock_val = tod; cpu_id = cid; operand = op; base_addr = base; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < words; k++) begin
      int ri;
      logic [3:0] ridx;
      if (k == 0)
        exp = {8'h70 | 8'(n), wd ? 8'h80 : 8'h00, wd ? tod[63:48] : ts[47:32]};
      else if (wd && k == 1) exp = ts[63:32];
      else if ((wd && k == 2) || (!wd && k == 1)) exp = ts[31:0];
      else if ((wd && k == 3) || (!wd && k == 2)) exp = op;
      else begin
        ri = wd ? (k - 4) / 2 : k - 3;
        ridx = 4'((r1 + ri) & 15);
        // R1
        check(rf_idx == ridx, "R1", "register index", 64'(rf_idx), 64'(ridx));
        if (wd) exp = ((k - 4) % 2 == 0) ? reg_val(ridx)[63:32] : reg_val(ridx)[31:0];
        else    exp = reg_val(ridx)[31:0];
      end
      // R6
      check(wr_en == 1'b1, "R6", "write enable during record", 64'(wr_en), 64'd1);
      check(wr_addr == base + 32'(4 * k), "R6", "write address", 64'(wr_addr), 64'(base + 32'(4 * k)));
      if (k == 0) begin
        // R2
        check(wr_data[31:16] == exp[31:16], "R2", "header tag bytes", 64'(wr_data[31:16]), 64'(exp[31:16]));
        // R3 R4
        check(wr_data[15:0] == exp[15:0], wd ? "R4" : "R3", "header timestamp", 64'(wr_data[15:0]), 64'(exp[15:0]));
      end else
        check(wr_data == exp, wd ? (k < 4 ? "R4" : "R5") : "R3", "record word", 64'(wr_data), 64'(exp));
      if (inject && k == 1) begin
        // R8: altered request while busy
        start = 1'b1; first_reg = ~first_reg; last_reg = last_reg + 4'd5;
        wide_mode = ~wide_mode; operand = ~operand; base_addr = 32'hFFF0_0000;
        clock_val = ~clock_val; cpu_id = ~cpu_id;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    // R7
    check(done == 1'b1, "R7", "done after last write", 64'(done), 64'd1);
    check(wr_en == 1'b0, "R6", "write enable after record", 64'(wr_en), 64'd0);
    check(done_size == (wd ? 8'(144 - (15 - n) * 8) : 8'(76 - (15 - n) * 4)),
          inject ? "R8" : "R7", "record size", 64'(done_size),
          64'(wd ? 144 - (15 - n) * 8 : 76 - (15 - n) * 4));
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "done pulse width", 64'({done, busy}), 64'd0);
  endtask

  initial begin
    int seq;
    seq = 0;
    repeat (3) @(negedge clk);
    // R9
    check(busy == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R9", "reset state",
          64'({busy, wr_en, done}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && wr_en == 1'b0 && done == 1'b0, "R9", "idle after reset",
          64'({busy, wr_en, done}), 64'd0);
    for (int w = 0; w < 2; w++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          run_entry(a, b, w[0], seq, ((a + b) % 5) == 0);
          seq++;
        end
    finish_run();
  end
endmodule